// File: doc/BRIEF.md
# Debug Monitor Entry Sequencer

This block takes a small microcontroller into its debug monitor. Two events start the sequence: a software-interrupt request, or the reset pin going from low to high. At the moment of entry the block captures the clock strap. If the strap is low, it selects a clock path that skips the divide-by-two stage.

The block then accepts exactly eight security bytes from a host through a byte-wide receive interface. It checks each byte on arrival against a stored eight-byte key. After the eighth byte it holds the serial transmit line low for ten baud periods. This break tells the host that the monitor is ready for commands. Once the break ends, the line returns high and a one-cycle ready pulse is given.

While the monitor is active, the block moves the vector high-address byte to the alternate page. It also suppresses the watchdog for as long as an elevated-voltage detect flag is present on either the interrupt pin or the reset pin.

The sequencer has four states:
- IDLE: waits for an entry event.
- WAIT_SEC: collects the security bytes.
- SEND_BREAK: drives the break.
- READY: the monitor is active.

It has five transitions:
- IDLE to WAIT_SEC on an entry event.
- WAIT_SEC to SEND_BREAK on the eighth accepted byte.
- SEND_BREAK to READY on the tenth baud tick.
- READY holds until reset.
- A synchronous reset returns every state to IDLE.

Top module: `dbgmon_entry_seq`

## Requirements
- R1: From IDLE, the sequence starts when `swi_req` is high at a clock edge, or when `rst_pin` is sampled high at one edge after being sampled low at the previous edge. `mon_active` goes high in the following cycle. With `rst_pin` held high and `swi_req` low, the block stays in IDLE.
- R2: In WAIT_SEC the block accepts exactly eight `rx_valid` bytes. `tx_line` stays high until the eighth byte is accepted and goes low in the next cycle.
- R3: During SEND_BREAK `tx_line` is low. It returns high in the cycle after the edge that samples the tenth `baud_tick` pulse.
- R4: `vec_page` is 8'hFE while `mon_active` is high and 8'hFF otherwise.
- R5: `wdog_disable` equals `mon_active AND (hv_irq OR hv_rst)` and follows the two detect flags in the same cycle.
- R6: On the entry edge, `clk_bypass` takes the inverse of `clk_strap`. It holds that value until reset, whatever the strap does afterwards. It is 0 after reset.
- R7: The n-th accepted byte (n = 0..7) is compared with `key_in[8n+7:8n]`. After the eighth byte, `sec_locked` is 1 if any byte differed and 0 if all eight matched. Monitor mode is entered in both cases.
- R8: `rx_valid` has no effect in SEND_BREAK or READY. The break length, `sec_locked` and `tx_line` are unchanged by it.
- R9: `ready_pulse` is high for exactly one cycle: the first cycle of READY.
- R10: A synchronous active-high `rst` returns the block to IDLE. After reset, `tx_line`=1, `vec_page`=8'hFF and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_pin | input | 1 | Reset pin level; a low-to-high transition starts entry |
| swi_req | input | 1 | Software-interrupt entry request |
| hv_irq | input | 1 | Elevated-voltage detect on the interrupt pin |
| hv_rst | input | 1 | Elevated-voltage detect on the reset pin |
| clk_strap | input | 1 | Clock strap; low selects the divider bypass |
| rx_valid | input | 1 | A received byte is present on rx_data |
| rx_data | input | 8 | Received byte |
| baud_tick | input | 1 | One pulse per serial bit period |
| key_in | input | 64 | Stored key, byte n in bits 8n+7:8n |
| tx_line | output | 1 | Serial transmit line, idle high |
| vec_page | output | 8 | Vector high-address byte |
| wdog_disable | output | 1 | Watchdog suppression |
| clk_bypass | output | 1 | Skip the clock divide-by-two stage |
| mon_active | output | 1 | Monitor mode active |
| sec_locked | output | 1 | Security check failed |
| ready_pulse | output | 1 | One-cycle pulse when the break completes |

## Verification
The key comparison is swept over nine security streams. In eight of them a single corrupted byte sits at each position 0 to 7, and the ninth matches the key completely. This separates a comparator that checks every byte from one that skips or reorders a position, and it shows that a mismatch still ends in READY.

Entry alternates between the reset-pin edge and the software request, and the strap value alternates across runs. This separates each entry path and the strap inversion, and it shows that the strap is latched rather than passed through live.

Each run checks the transmit line after the seventh byte and before and after the tenth baud tick. Spurious receive strobes are inserted during the break. These patterns expose an off-by-one in the byte count or the break length, and they show whether the receive path is truly ignored.

// File: rtl/dbgmon_pkg.sv
package dbgmon_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_SEC,
        ST_SEND_BREAK,
        ST_READY
    } dbgmon_state_t;

    localparam logic [7:0] VEC_PAGE_USER = 8'hFF;
    localparam logic [7:0] VEC_PAGE_MON  = 8'hFE;
endpackage

// File: rtl/dbgmon_entry_detect.sv
// Entry event detection and strap capture (R1, R6).
module dbgmon_entry_detect (
    input  logic clk,
    input  logic rst,
    input  logic rst_pin,
    input  logic swi_req,
    input  logic capture,
    input  logic clk_strap,
    output logic entry_req,
    output logic bypass_q
);
    logic pin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q    <= 1'b1;
            bypass_q <= 1'b0;
        end else begin
            pin_q <= rst_pin;
            if (capture) begin
                bypass_q <= ~clk_strap;
            end
        end
    end

    assign entry_req = swi_req | (rst_pin & ~pin_q);
endmodule

// File: rtl/dbgmon_key_check.sv
// On-the-fly comparison of received bytes with the stored key (R2, R7).
module dbgmon_key_check #(
    parameter int NKEY = 8,
    parameter int W    = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            accept,
    input  logic [W-1:0]    rx_data,
    input  logic [NKEY*W-1:0] key_in,
    output logic            last_byte,
    output logic            match_final
);
    localparam int IDXW = (NKEY > 1) ? $clog2(NKEY) : 1;
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NKEY - 1);

    logic [IDXW-1:0] idx;
    logic            match_q;
    logic [W-1:0]    key_sel;
    logic            hit;

    assign key_sel     = key_in[idx*W +: W];
    assign hit         = (rx_data == key_sel);
    assign last_byte   = accept && (idx == LAST_IDX);
    assign match_final = match_q & hit;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx     <= '0;
            match_q <= 1'b1;
        end else if (accept) begin
            idx     <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
            match_q <= match_q & hit;
        end
    end
endmodule

// File: rtl/dbgmon_break_timer.sv
// Counts baud ticks while the break is driven (R3).
module dbgmon_break_timer #(
    parameter int BRK_BITS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(BRK_BITS + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(BRK_BITS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && tick && (cnt == LAST_CNT);
endmodule

// File: rtl/dbgmon_entry_seq.sv
module dbgmon_entry_seq
    import dbgmon_pkg::*;
#(
    parameter int NKEY     = 8,
    parameter int W        = 8,
    parameter int BRK_BITS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_pin,
    input  logic              swi_req,
    input  logic              hv_irq,
    input  logic              hv_rst,
    input  logic              clk_strap,
    input  logic              rx_valid,
    input  logic [W-1:0]      rx_data,
    input  logic              baud_tick,
    input  logic [NKEY*W-1:0] key_in,
    output logic              tx_line,
    output logic [7:0]        vec_page,
    output logic              wdog_disable,
    output logic              clk_bypass,
    output logic              mon_active,
    output logic              sec_locked,
    output logic              ready_pulse
);
    dbgmon_state_t state, nxt;

    logic entry_req;
    logic enter;
    logic accept;
    logic last_byte;
    logic match_final;
    logic brk_run;
    logic brk_done;

    assign enter   = (state == ST_IDLE) && entry_req;
    assign accept  = (state == ST_WAIT_SEC) && rx_valid;
    assign brk_run = (state == ST_SEND_BREAK);

    dbgmon_entry_detect u_detect (
        .clk       (clk),
        .rst       (rst),
        .rst_pin   (rst_pin),
        .swi_req   (swi_req),
        .capture   (enter),
        .clk_strap (clk_strap),
        .entry_req (entry_req),
        .bypass_q  (clk_bypass)
    );

    dbgmon_key_check #(.NKEY(NKEY), .W(W)) u_key (
        .clk         (clk),
        .rst         (rst),
        .clear       (enter),
        .accept      (accept),
        .rx_data     (rx_data),
        .key_in      (key_in),
        .last_byte   (last_byte),
        .match_final (match_final)
    );

    dbgmon_break_timer #(.BRK_BITS(BRK_BITS)) u_brk (
        .clk  (clk),
        .rst  (rst),
        .run  (brk_run),
        .tick (baud_tick),
        .done (brk_done)
    );

    // State register (R10)
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (enter)     nxt = ST_WAIT_SEC;
            ST_WAIT_SEC:   if (last_byte) nxt = ST_SEND_BREAK;
            ST_SEND_BREAK: if (brk_done)  nxt = ST_READY;
            ST_READY:                     nxt = ST_READY;
            default:                      nxt = ST_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            sec_locked  <= 1'b0;
            ready_pulse <= 1'b0;
        end else begin
            ready_pulse <= brk_done;
            if (last_byte) begin
                sec_locked <= ~match_final;
            end
        end
    end

    // State-decoded outputs
    always_comb begin
        mon_active   = (state != ST_IDLE);
        tx_line      = (state != ST_SEND_BREAK);
        vec_page     = mon_active ? VEC_PAGE_MON : VEC_PAGE_USER;
        wdog_disable = mon_active & (hv_irq | hv_rst);
    end
endmodule

// File: rtl/dbgmon_entry_seq_chk.sv
module dbgmon_entry_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       hv_irq,
    input logic       hv_rst,
    input logic       tx_line,
    input logic [7:0] vec_page,
    input logic       wdog_disable,
    input logic       clk_bypass,
    input logic       mon_active,
    input logic       sec_locked,
    input logic       ready_pulse
);
    // R4
    a_r4_vec_page: assert property (@(posedge clk) disable iff (rst)
        (vec_page == 8'hFE) || (vec_page == 8'hFF && !mon_active));

    // R5
    a_r5_wdog_gate: assert property (@(posedge clk) disable iff (rst)
        wdog_disable |-> (mon_active && (hv_irq || hv_rst)));

    // R6
    a_r6_bypass_held: assert property (@(posedge clk) disable iff (rst)
        (mon_active && $past(mon_active)) |-> $stable(clk_bypass));

    // R3
    a_r3_break_in_monitor: assert property (@(posedge clk) disable iff (rst)
        !tx_line |-> mon_active);

    // R9
    a_r9_ready_single: assert property (@(posedge clk) disable iff (rst)
        ready_pulse |=> !ready_pulse);

    // R9
    a_r9_ready_after_break: assert property (@(posedge clk) disable iff (rst)
        ready_pulse |-> (tx_line && $past(!tx_line)));

    // R7
    a_r7_lock_stable_ready: assert property (@(posedge clk) disable iff (rst)
        (tx_line && $past(tx_line) && $past(sec_locked) && mon_active) |-> sec_locked);

    // R10
    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> (!mon_active && tx_line && !sec_locked && !ready_pulse && !clk_bypass));
endmodule

bind dbgmon_entry_seq dbgmon_entry_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .hv_irq       (hv_irq),
    .hv_rst       (hv_rst),
    .tx_line      (tx_line),
    .vec_page     (vec_page),
    .wdog_disable (wdog_disable),
    .clk_bypass   (clk_bypass),
    .mon_active   (mon_active),
    .sec_locked   (sec_locked),
    .ready_pulse  (ready_pulse)
);

// File: tb/sim_dbgmon_entry_seq.sv
module sim_dbgmon_entry_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rst_pin = 1'b1;
    logic        swi_req = 1'b0;
    logic        hv_irq = 1'b0;
    logic        hv_rst = 1'b0;
    logic        clk_strap = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        baud_tick = 1'b0;
    logic [63:0] key_in = 64'hC3_5E_91_07_AA_48_1D_F2;

    logic        tx_line;
    logic [7:0]  vec_page;
    logic        wdog_disable;
    logic        clk_bypass;
    logic        mon_active;
    logic        sec_locked;
    logic        ready_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dbgmon_entry_seq u0 (
        .clk(clk), .rst(rst), .rst_pin(rst_pin), .swi_req(swi_req),
        .hv_irq(hv_irq), .hv_rst(hv_rst), .clk_strap(clk_strap),
        .rx_valid(rx_valid), .rx_data(rx_data), .baud_tick(baud_tick),
        .key_in(key_in), .tx_line(tx_line), .vec_page(vec_page),
        .wdog_disable(wdog_disable), .clk_bypass(clk_bypass),
        .mon_active(mon_active), .sec_locked(sec_locked),
        .ready_pulse(ready_pulse)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; rst_pin = 1'b1; swi_req = 1'b0; rx_valid = 1'b0; baud_tick = 1'b0;
        cyc(); cyc();
        rst = 1'b0;
        cyc();
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        cyc();
        rx_valid = 1'b0;
        cyc();
    endtask

    task automatic tick();
        baud_tick = 1'b1;
        cyc();
        baud_tick = 1'b0;
    endtask

    initial begin
        #3000000;
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10 reset state
        check("R10 tx_line", tx_line, 1);
        check("R10 vec_page", vec_page, 8'hFF);
        check("R10 mon_active", mon_active, 0);
        check("R10 sec_locked", sec_locked, 0);
        check("R10 ready_pulse", ready_pulse, 0);
        check("R10 clk_bypass", clk_bypass, 0);
        hv_irq = 1'b1;
        cyc();
        check("R5 idle no wdog", wdog_disable, 0);
        hv_irq = 1'b0;
        // R1 no spurious entry
        for (int i = 0; i < 5; i++) cyc();
        check("R1 stays idle", mon_active, 0);
        check("R4 user page idle", vec_page, 8'hFF);

        for (int run = 0; run < 9; run++) begin
            bit use_swi;
            bit strap;
            bit exp_lock;
            use_swi  = run[0];
            strap    = run[1];
            exp_lock = (run < 8);
            do_reset();
            clk_strap = strap;
            if (use_swi) begin
                swi_req = 1'b1;
                cyc();
                swi_req = 1'b0;
            end else begin
                rst_pin = 1'b0;
                cyc();
                rst_pin = 1'b1;
                cyc();
            end
            check(use_swi ? "R1 swi entry" : "R1 pin edge entry", mon_active, 1);
            check("R4 monitor page", vec_page, 8'hFE);
            check("R6 bypass latched", clk_bypass, !strap);
            clk_strap = !strap;
            cyc();
            check("R6 bypass held after strap change", clk_bypass, !strap);
            // R5 live watchdog gate
            hv_irq = 1'b0; hv_rst = 1'b0; cyc();
            check("R5 no flags", wdog_disable, 0);
            hv_irq = 1'b1; cyc();
            check("R5 irq flag", wdog_disable, 1);
            hv_irq = 1'b0; hv_rst = 1'b1; cyc();
            check("R5 rst flag", wdog_disable, 1);
            hv_rst = 1'b0; cyc();
            check("R5 flags dropped", wdog_disable, 0);
            // security bytes
            for (int b = 0; b < 8; b++) begin
                logic [7:0] kb;
                kb = key_in[b*8 +: 8];
                if (b == run) kb = kb ^ 8'h5A;
                if (b == 7) begin
                    rx_valid = 1'b1; rx_data = kb;
                    cyc();
                    rx_valid = 1'b0;
                    check("R2 break after eighth byte", tx_line, 0);
                end else begin
                    send_byte(kb);
                    if (b == 6) check("R2 no break after seventh byte", tx_line, 1);
                end
            end
            check("R7 lock result", sec_locked, exp_lock);
            // break with spurious receive strobes (R8)
            for (int t = 0; t < 9; t++) begin
                tick();
                rx_valid = 1'b1; rx_data = 8'h00;
                cyc();
                rx_valid = 1'b0;
            end
            check("R3 still low after nine ticks", tx_line, 0);
            check("R8 lock unchanged in break", sec_locked, exp_lock);
            check("R9 no early ready", ready_pulse, 0);
            tick();
            check("R3 high after tenth tick", tx_line, 1);
            check("R9 ready pulse", ready_pulse, 1);
            cyc();
            check("R9 ready one cycle", ready_pulse, 0);
            rx_valid = 1'b1; rx_data = 8'hFF;
            cyc();
            rx_valid = 1'b0;
            cyc();
            check("R8 ready ignores rx tx", tx_line, 1);
            check("R8 ready ignores rx lock", sec_locked, exp_lock);
            check("R7 monitor entered", mon_active, 1);
        end

        // R10 reset from READY
        rst = 1'b1;
        cyc();
        rst = 1'b0;
        cyc();
        check("R10 reset from ready", mon_active, 0);
        check("R10 page restored", vec_page, 8'hFF);
        check("R10 lock cleared", sec_locked, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule